// File: doc/BRIEF.md
# Multi-Channel DMA Bus Arbiter

This block decides which of several DMA channels may drive a single shared memory bus. Each channel raises a request line when it has a block ready to move. The arbiter answers with a one-hot grant. The winning channel then owns the bus for its entire block, however long that takes. Ownership returns to arbitration only when that channel pulses its block-done line. A block is therefore never split between two channels.

The selection method is chosen at run time by one policy input. When it is low, the lowest-numbered requester always wins. When it is high, the arbiter rotates fairly: the search begins at the channel just after the last one served. A change of policy while a grant is held waits until the next arbitration point. The grant is registered, so a decision shows on the grant lines one clock after the requests it was based on.

Top module: `dma_bus_arbiter`

## Requirements
- R1: An active-low asynchronous reset clears every grant line and bus_busy_o immediately. After reset, the rotating search starts at channel 0.
- R2: grant_o never has more than one bit set. It is all zeros after an arbitration point at which no channel requested.
- R3: An arbitration point is any rising clock edge where either no grant is held or the held channel's blk_done_i bit is high. At that edge grant_o loads the winner among the req_i bits present then. A request change between edges does not alter grant_o until the next edge.
- R4: With rr_mode_i = 0, bit i of grant_o is given to the lowest index i whose req_i bit is set.
- R5: With rr_mode_i = 1, the search begins at the index one above the most recently granted channel and wraps from channel 7 to channel 0. If the only requester is the last-served channel, it is granted again.
- R6: While a grant is held and the holder's blk_done_i bit is low, grant_o does not change. This holds whatever the other requests do, and even if the holder lowers its own request.
- R7: A blk_done_i bit from a channel that does not hold the grant has no effect.
- R8: A change of rr_mode_i during a held grant takes effect only at the next arbitration point.
- R9: bus_busy_o is high exactly when some grant_o bit is set.
- R10: When the holder signals done, the next grant is loaded at that same edge with no idle cycle. If no other channel is requesting, grant_o becomes all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_CH | Per-channel bus request |
| blk_done_i | input | N_CH | Per-channel end-of-block pulse |
| rr_mode_i | input | 1 | Policy: 0 fixed priority, 1 round robin |
| grant_o | output | N_CH | One-hot bus grant |
| bus_busy_o | output | 1 | Bus currently owned by a channel |

## Verification
The bench tests the hold rule in several ways:
- Higher-priority requests arrive while a grant is held.
- The holder lowers its own request.
- A different channel pulses done.

A design that re-arbitrated on any of these would hand over the bus in the middle of a block.

It also tests the policy and rotation rules:
- The policy is flipped during a hold; a design that ignored the arbitration point would switch owners early.
- The rotation is driven across the wrap from channel 7 to 0 and with a single repeating requester; an off-by-one pointer would pick the wrong channel.
- Handover on done with and without pending requests catches a design that inserts idle cycles or leaves a stale grant.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   typedef enum logic {
      POL_FIXED = 1'b0,
      POL_ROTATE = 1'b1
   } arb_policy_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/dma_arb_prio.sv
module dma_arb_prio #(
   parameter int N = 8
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] win_o,
   output logic         any_o
);
   logic [N:0] seen;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign win_o[i]    = req_i[i] & ~seen[i];
      assign seen[i+1]   = seen[i] | req_i[i];
   end

   assign any_o = seen[N];
endmodule

// File: rtl/dma_arb_rotate.sv
module dma_arb_rotate #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req_i,
   input  logic [IDX_W-1:0] last_i,
   output logic [N-1:0]     win_o
);
   logic [N-1:0] above;
   logic [N-1:0] hi_win, all_win;
   logic         hi_any, all_any;

   for (genvar i = 0; i < N; i++) begin : g_mask
      localparam logic [IDX_W-1:0] POS = IDX_W'(i);
      assign above[i] = POS > last_i;
   end

   dma_arb_prio #(.N(N)) u_hi (
      .req_i(req_i & above),
      .win_o(hi_win),
      .any_o(hi_any)
   );

   dma_arb_prio #(.N(N)) u_all (
      .req_i(req_i),
      .win_o(all_win),
      .any_o(all_any)
   );

   assign win_o = hi_any ? hi_win : (all_any ? all_win : '0);
endmodule

// File: rtl/dma_arb_encode.sv
module dma_arb_encode #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     onehot_i,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (onehot_i[i]) idx_o = idx_o | IDX_W'(i);
      end
   end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
   import dma_arb_pkg::*;
#(
   parameter int N_CH      = 8,
   parameter bit RR_ENABLE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] req_i,
   input  logic [N_CH-1:0] blk_done_i,
   input  logic            rr_mode_i,
   output logic [N_CH-1:0] grant_o,
   output logic            bus_busy_o
);
   localparam int IDX_W = idx_width(N_CH);
   localparam logic [IDX_W-1:0] LAST_INIT = IDX_W'(N_CH - 1);

   if (N_CH < 2) begin : g_bad_n
      $error("dma_bus_arbiter: N_CH must be at least 2");
   end

   logic [N_CH-1:0]  grant_q;
   logic [IDX_W-1:0] last_q;
   logic [N_CH-1:0]  fix_win, rot_win, pick;
   logic [IDX_W-1:0] pick_idx;
   logic             fix_any, holder_done, arb_pt;
   arb_policy_e      policy;

   assign policy = arb_policy_e'(rr_mode_i);

   dma_arb_prio #(.N(N_CH)) u_fixed (
      .req_i(req_i),
      .win_o(fix_win),
      .any_o(fix_any)
   );

   if (RR_ENABLE) begin : g_rotate
      dma_arb_rotate #(.N(N_CH), .IDX_W(IDX_W)) u_rot (
         .req_i (req_i),
         .last_i(last_q),
         .win_o (rot_win)
      );
   end else begin : g_fixed_only
      assign rot_win = fix_win;
   end

   assign pick = (policy == POL_ROTATE) ? rot_win : fix_win;

   dma_arb_encode #(.N(N_CH), .IDX_W(IDX_W)) u_enc (
      .onehot_i(pick),
      .idx_o   (pick_idx)
   );

   assign holder_done = |(grant_q & blk_done_i);
   assign arb_pt      = ~(|grant_q) | holder_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= '0;
         last_q  <= LAST_INIT;
      end else if (arb_pt) begin
         grant_q <= pick;
         if (fix_any) last_q <= pick_idx;
      end
   end

   assign grant_o    = grant_q;
   assign bus_busy_o = |grant_q;

   // R2: at most one owner
   assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   // R2: nobody asking means nobody granted
   assert_idle_no_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_pt && req_i == '0) |=> grant_o == '0);

   // R6 / R7: held grant is stable until the holder itself reports done
   assert_hold_until_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((|grant_o) && !(|(grant_o & blk_done_i))) |=> $stable(grant_o));

   // R3: a new grant only goes to a channel that was requesting
   assert_grant_to_requester_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_pt && req_i != '0) |=> ((grant_o & $past(req_i)) == grant_o && grant_o != '0));

   // R4: fixed policy picks the lowest set request bit
   assert_fixed_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_pt && !rr_mode_i && req_i != '0) |=>
         grant_o == ($past(req_i) & (~$past(req_i) + 1'b1)));

endmodule

// File: tb/dma_bus_arbiter_test.sv
module dma_bus_arbiter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req = '0;
   logic [7:0] done = '0;
   logic       rr = 1'b0;
   logic [7:0] grant;
   logic       busy;
   int         n_run = 0;
   int         n_fail = 0;

   always #2 clk = ~clk;

   dma_bus_arbiter #(.N_CH(8)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req),
      .blk_done_i(done),
      .rr_mode_i (rr),
      .grant_o   (grant),
      .bus_busy_o(busy)
   );

   // {req[31:24], done[23:16], rr[15], tag[14:8], expected grant[7:0]}
   localparam int NV = 18;
   localparam logic [31:0] VEC [NV] = '{
      32'h00000200, // R2 idle, no requests
      32'h2C000404, // R4 ch2 beats ch3,ch5
      32'h03000604, // R6 higher requests while held
      32'h00080704, // R6 R7 holder drops req, ch3 done ignored
      32'h0A040A02, // R10 R4 handover to ch1 same edge
      32'h0A008802, // R8 policy flip while held
      32'h0A028508, // R5 rotate from ch2 -> ch3
      32'h8A088580, // R5 rotate from ch4 -> ch7
      32'h8A808502, // R5 wrap 7 -> ch1
      32'h02028502, // R5 sole requester regranted
      32'h00028A00, // R10 done with no requests
      32'h00000200, // R2 stays idle
      32'h81000401, // R4 ch0 beats ch7
      32'h81010401, // R4 fixed favours ch0 again
      32'h81018880, // R8 rotate applies at arb point -> ch7
      32'hFF808501, // R5 wrap to ch0
      32'hFF018502, // R5 next in turn ch1
      32'h00028A00  // R10 release
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #1;
      chk("R1 grant in reset", grant, 8'h00);
      chk("R1 busy in reset", {7'b0, busy}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         req  = VEC[v][31:24];
         done = VEC[v][23:16];
         rr   = VEC[v][15];
         @(posedge clk);
         #1;
         chk($sformatf("R%0d vector %0d", VEC[v][14:8], v), grant, VEC[v][7:0]);
         chk($sformatf("R9 vector %0d", v), {7'b0, busy}, {7'b0, VEC[v][7:0] != 8'h00});
      end

      // R3: grant is registered, no change before the edge
      @(negedge clk);
      req = 8'h10; done = 8'h00; rr = 1'b0;
      #1;
      chk("R3 before edge", grant, 8'h00);
      @(posedge clk);
      #1;
      chk("R3 after edge", grant, 8'h10);

      // R1: reset during a held grant clears it at once
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 async clear grant", grant, 8'h00);
      chk("R1 async clear busy", {7'b0, busy}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      req = 8'h81; rr = 1'b1;
      @(posedge clk);
      #1;
      chk("R5 rotate starts at ch0 after reset", grant, 8'h01);

      @(negedge clk);
      req = 8'h00; done = 8'h01;
      @(posedge clk);
      #1;
      chk("R10 final release", grant, 8'h00);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule